// File: doc/BRIEF.md
# Interrupt Vector Table with Pending Bits

This block stores the message for each of `NVEC` interrupt vectors: a 64-bit message address, held as a low and a high word, a 32-bit data word, and a control word whose bit 0 masks the vector. Next to the table it keeps one pending bit per vector. A host port reads and writes the table in 4-byte or 8-byte accesses and reads the pending bits. Device logic raises interrupt requests by vector number. The block either sends the vector's message at once on a valid/ready message channel, or records the request as a pending bit.

A pending bit stays set until its vector may deliver. That needs three things: the function is enabled, the function mask is clear, and the vector's own mask bit is clear. Clearing the vector mask through a table write is one way to open it. Clearing the function mask is another. Once the vector may deliver, the stored message is sent and the pending bit is cleared in the cycle its handshake completes. The function enable and the function mask are plain inputs, driven by the configuration logic outside the block. `NVEC` may range from 2 to 2048.

Top module: `msix_vector_store`

## Requirements
- R1: After reset, every entry's address and data words read 0, every control word reads 0x1 (masked), all pending bits read 0, and no message is offered.
- R2: A 4-byte table access at byte offset 16*e+k reaches entry e. The offset k selects the field: 0x0 address low, 0x4 address high, 0x8 data, 0xC control. Read data is returned in bits 31:0, with bits 63:32 zero.
- R3: An 8-byte table access at k=0x0 carries address low in bits 31:0 and address high in bits 63:32. One at k=0x8 carries data in bits 31:0 and control in bits 63:32.
- R4: Some table accesses read 0 and have no effect on writes: a 4-byte access with k not a multiple of 4, and an 8-byte access with k other than 0x0 or 0x8.
- R5: Pending bit v lies in pending word v/64 at bit v%64, and word w sits at byte 8*w of the pending region. A 4-byte read at byte 0 of a word returns bits 31:0, and one at byte 4 returns bits 63:32. An 8-byte read at byte 0 returns the whole word. Bits that map to no vector read 0.
- R6: Host writes to the pending region change no pending bit.
- R7: The block sends a device request for vector v directly, without setting a pending bit, when four things hold: the function is enabled, the function is unmasked, vector v is unmasked, and the message slot is free with no pending candidate. The message (address = {high, low}, data) is offered after the next clock edge.
- R8: Every other in-range device request sets pending bit v.
- R9: A pending vector is loaded into a free message slot once it may deliver (function enabled and unmasked, vector unmasked), with the lowest vector number first. Its pending bit clears on the cycle its handshake completes.
- R10: An offered message holds its valid, address and data stable until it is accepted.
- R11: A host read returns its data with a valid strobe one cycle after the request. No strobe appears for writes or idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| func_enable | input | 1 | Function-level enable |
| func_mask | input | 1 | Function-level mask |
| host_req | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| host_pba | input | 1 | 1 = pending region, 0 = table region |
| host_addr | input | AW | Byte offset within the selected region |
| host_wdata | input | 64 | Write data, little-endian |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 64 | Read data |
| dev_req | input | 1 | Device interrupt request |
| dev_vec | input | VW | Requested vector number |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The hardest case to reach is a pending vector that is released while the message channel is stalled. It needs a masked vector with a recorded request, an unmask through a table write, and a receiver that holds ready low. The stimulus builds this in order. It records requests on a masked vector whose pending bit sits in the second pending word. It unmasks that vector with ready low, holds the message for several cycles, and reads the pending bit while the message is still in flight, then raises ready. A random phase then mixes function-mask toggles, control writes and stalled handshakes, and a behavioural model checks every cycle.

// File: rtl/msix_vector_store.sv
module msix_vector_store #(
  parameter int NVEC = 72,
  localparam int VW = (NVEC > 1) ? $clog2(NVEC) : 1,
  localparam int AW = $clog2(NVEC * 16)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          func_enable,
  input  logic          func_mask,
  input  logic          host_req,
  input  logic          host_we,
  input  logic          host_wide,
  input  logic          host_pba,
  input  logic [AW-1:0] host_addr,
  input  logic [63:0]   host_wdata,
  output logic          host_rvalid,
  output logic [63:0]   host_rdata,
  input  logic          dev_req,
  input  logic [VW-1:0] dev_vec,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [63:0]   msg_addr,
  output logic [31:0]   msg_data
);
  localparam int IW = AW - 4;

  logic [31:0] t_lo [NVEC];
  logic [31:0] t_hi [NVEC];
  logic [31:0] t_dat [NVEC];
  logic [31:0] t_ctl [NVEC];
  logic [NVEC-1:0] pend;
  logic [VW-1:0] msg_vec;
  logic msg_from_pend;

  logic [IW-1:0] hidx, hsel;
  logic [3:0] hoff;
  logic hin, wr;
  assign hidx = host_addr[AW-1:4];
  assign hoff = host_addr[3:0];
  assign hin  = int'(hidx) < NVEC;
  assign hsel = hin ? hidx : '0;
  assign wr   = host_req && host_we && !host_pba && hin;

  logic w_lo, w_hi, w_dat, w_ctl;
  assign w_lo  = wr && (hoff == 4'h0);
  assign w_hi  = wr && (host_wide ? hoff == 4'h0 : hoff == 4'h4);
  assign w_dat = wr && (hoff == 4'h8);
  assign w_ctl = wr && (host_wide ? hoff == 4'h8 : hoff == 4'hC);

  logic [31:0] v_hi, v_ctl;
  assign v_hi  = host_wide ? host_wdata[63:32] : host_wdata[31:0];
  assign v_ctl = host_wide ? host_wdata[63:32] : host_wdata[31:0];

  logic [63:0] tbl_rd, pw, pba_rd, rd_val;
  always_comb begin
    tbl_rd = '0;
    if (host_wide) begin
      if (hoff == 4'h0) tbl_rd = {t_hi[hsel], t_lo[hsel]};
      else if (hoff == 4'h8) tbl_rd = {t_ctl[hsel], t_dat[hsel]};
    end else begin
      case (hoff)
        4'h0: tbl_rd = {32'h0, t_lo[hsel]};
        4'h4: tbl_rd = {32'h0, t_hi[hsel]};
        4'h8: tbl_rd = {32'h0, t_dat[hsel]};
        4'hC: tbl_rd = {32'h0, t_ctl[hsel]};
        default: tbl_rd = '0;
      endcase
    end
  end

  always_comb begin
    int v;
    pw = '0;
    for (int b = 0; b < 64; b++) begin
      v = int'(host_addr[AW-1:3]) * 64 + b;
      if (v < NVEC) pw[b] = pend[v];
    end
  end

  always_comb begin
    pba_rd = '0;
    if (host_wide) begin
      if (host_addr[2:0] == 3'd0) pba_rd = pw;
    end else if (host_addr[2:0] == 3'd0) pba_rd = {32'h0, pw[31:0]};
    else if (host_addr[2:0] == 3'd4) pba_rd = {32'h0, pw[63:32]};
  end

  assign rd_val = (!host_req || host_we) ? '0 :
                  host_pba ? pba_rd : (hin ? tbl_rd : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= host_req && !host_we;
      host_rdata  <= rd_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NVEC; i++) begin
        t_lo[i]  <= '0;
        t_hi[i]  <= '0;
        t_dat[i] <= '0;
        t_ctl[i] <= 32'h1;
      end
    end else begin
      if (w_lo)  t_lo[hsel]  <= host_wdata[31:0];
      if (w_hi)  t_hi[hsel]  <= v_hi;
      if (w_dat) t_dat[hsel] <= host_wdata[31:0];
      if (w_ctl) t_ctl[hsel] <= v_ctl;
    end
  end

  logic open, free, cand_ok, dok, load_pend, load_dev, set_dev, clr;
  logic [VW-1:0] cand, dsel;
  assign open = func_enable && !func_mask;
  assign free = !msg_valid || msg_ready;
  assign dok  = dev_req && (int'(dev_vec) < NVEC);
  assign dsel = dok ? dev_vec : '0;

  always_comb begin
    cand_ok = 1'b0;
    cand    = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (pend[i] && !t_ctl[i][0] && open && !(msg_valid && int'(msg_vec) == i)) begin
        cand_ok = 1'b1;
        cand    = VW'(i);
      end
    end
  end

  assign load_pend = free && cand_ok;
  assign load_dev  = free && !cand_ok && dok && open && !t_ctl[dsel][0];
  assign set_dev   = dok && !load_dev;
  assign clr       = msg_valid && msg_ready && msg_from_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else begin
      for (int i = 0; i < NVEC; i++) begin
        if (set_dev && int'(dsel) == i) pend[i] <= 1'b1;
        else if (clr && int'(msg_vec) == i) pend[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid     <= 1'b0;
      msg_vec       <= '0;
      msg_from_pend <= 1'b0;
      msg_addr      <= '0;
      msg_data      <= '0;
    end else if (load_pend) begin
      msg_valid     <= 1'b1;
      msg_vec       <= cand;
      msg_from_pend <= 1'b1;
      msg_addr      <= {t_hi[cand], t_lo[cand]};
      msg_data      <= t_dat[cand];
    end else if (load_dev) begin
      msg_valid     <= 1'b1;
      msg_vec       <= dsel;
      msg_from_pend <= 1'b0;
      msg_addr      <= {t_hi[dsel], t_lo[dsel]};
      msg_data      <= t_dat[dsel];
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  assert_read_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we) |=> host_rvalid);

  assert_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && !host_we) |=> !host_rvalid);

  assert_open_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(func_enable && !func_mask));

  assert_pend_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && msg_from_pend && !(dev_req && dev_vec == msg_vec))
      |=> !pend[$past(msg_vec)]);

  assert_pba_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && host_pba && !dev_req && !(msg_valid && msg_ready))
      |=> pend == $past(pend));
endmodule

// File: tb/msix_vector_store_test.sv
module msix_vector_store_test;
  localparam int NV = 72;
  localparam int VW = $clog2(NV);
  localparam int AW = $clog2(NV * 16);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fen = 1'b0, fmask = 1'b1;
  logic h_req = 1'b0, h_we = 1'b0, h_wide = 1'b0, h_pba = 1'b0;
  logic [AW-1:0] h_addr = '0;
  logic [63:0] h_wdata = '0;
  logic rvalid;
  logic [63:0] rdata;
  logic d_req = 1'b0;
  logic [VW-1:0] d_vec = '0;
  logic mvalid, rdy = 1'b0;
  logic [63:0] maddr;
  logic [31:0] mdata;

  always #5 clk = ~clk;

  msix_vector_store #(.NVEC(NV)) uut (
    .clk(clk), .rst_n(rst_n), .func_enable(fen), .func_mask(fmask),
    .host_req(h_req), .host_we(h_we), .host_wide(h_wide), .host_pba(h_pba),
    .host_addr(h_addr), .host_wdata(h_wdata), .host_rvalid(rvalid), .host_rdata(rdata),
    .dev_req(d_req), .dev_vec(d_vec), .msg_valid(mvalid), .msg_ready(rdy),
    .msg_addr(maddr), .msg_data(mdata));

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  logic [31:0] m_lo [NV];
  logic [31:0] m_hi [NV];
  logic [31:0] m_dat [NV];
  logic [31:0] m_ctl [NV];
  bit m_pend [NV];
  bit m_mv, m_mfp, m_rv;
  int m_mvec;
  logic [63:0] m_maddr, m_rd;
  logic [31:0] m_mdata;

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NV; i++) begin
      m_lo[i] = 0; m_hi[i] = 0; m_dat[i] = 0; m_ctl[i] = 1; m_pend[i] = 0;
    end
    m_mv = 0; m_mfp = 0; m_rv = 0; m_mvec = 0; m_maddr = 0; m_mdata = 0; m_rd = 0;
  endtask

  task automatic model_step();
    logic [63:0] rv = 0, pword = 0;
    int e, off, cand, dv;
    bit open, free, cand_ok, dok, ldp, ldd;
    if (h_req && !h_we) begin
      if (h_pba) begin
        for (int b = 0; b < 64; b++)
          if (int'(h_addr) / 8 * 64 + b < NV) pword[b] = m_pend[int'(h_addr) / 8 * 64 + b];
        off = int'(h_addr) % 8;
        if (h_wide) rv = (off == 0) ? pword : 64'h0;
        else if (off == 0) rv = {32'h0, pword[31:0]};
        else if (off == 4) rv = {32'h0, pword[63:32]};
      end else begin
        e = int'(h_addr) / 16; off = int'(h_addr) % 16;
        if (e < NV) begin
          if (h_wide) begin
            if (off == 0) rv = {m_hi[e], m_lo[e]};
            else if (off == 8) rv = {m_ctl[e], m_dat[e]};
          end else if (off == 0) rv = {32'h0, m_lo[e]};
          else if (off == 4) rv = {32'h0, m_hi[e]};
          else if (off == 8) rv = {32'h0, m_dat[e]};
          else if (off == 12) rv = {32'h0, m_ctl[e]};
        end
      end
    end
    open = fen && !fmask;
    free = !m_mv || rdy;
    cand_ok = 0; cand = 0;
    for (int i = 0; i < NV; i++)
      if (!cand_ok && m_pend[i] && !m_ctl[i][0] && open && !(m_mv && m_mvec == i)) begin
        cand_ok = 1; cand = i;
      end
    dv = int'(d_vec);
    dok = d_req && dv < NV;
    ldp = free && cand_ok;
    ldd = free && !cand_ok && dok && open && !m_ctl[dv][0];
    if (m_mv && rdy && m_mfp) m_pend[m_mvec] = 0;
    if (dok && !ldd) m_pend[dv] = 1;
    if (ldp) begin
      m_mv = 1; m_mfp = 1; m_mvec = cand; m_maddr = {m_hi[cand], m_lo[cand]}; m_mdata = m_dat[cand];
    end else if (ldd) begin
      m_mv = 1; m_mfp = 0; m_mvec = dv; m_maddr = {m_hi[dv], m_lo[dv]}; m_mdata = m_dat[dv];
    end else if (rdy) m_mv = 0;
    if (h_req && h_we && !h_pba) begin
      e = int'(h_addr) / 16; off = int'(h_addr) % 16;
      if (e < NV) begin
        if (h_wide) begin
          if (off == 0) begin m_lo[e] = h_wdata[31:0]; m_hi[e] = h_wdata[63:32]; end
          else if (off == 8) begin m_dat[e] = h_wdata[31:0]; m_ctl[e] = h_wdata[63:32]; end
        end else if (off == 0) m_lo[e] = h_wdata[31:0];
        else if (off == 4) m_hi[e] = h_wdata[31:0];
        else if (off == 8) m_dat[e] = h_wdata[31:0];
        else if (off == 12) m_ctl[e] = h_wdata[31:0];
      end
    end
    m_rv = h_req && !h_we;
    m_rd = rv;
  endtask

  task automatic compare();
    chk(cur_req, "msg_valid", 64'(mvalid), 64'(m_mv));
    if (m_mv) begin
      chk(cur_req, "msg_addr", maddr, m_maddr);
      chk(cur_req, "msg_data", 64'(mdata), 64'(m_mdata));
    end
    chk(cur_req, "host_rvalid", 64'(rvalid), 64'(m_rv));
    if (m_rv) chk(cur_req, "host_rdata", rdata, m_rd);
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    h_req = 0; h_we = 0; d_req = 0;
  endtask

  task automatic hwrite(bit pba, bit wide, int addr, logic [63:0] data);
    h_req = 1; h_we = 1; h_pba = pba; h_wide = wide; h_addr = AW'(addr); h_wdata = data;
    tick();
  endtask

  task automatic hread(string tag, bit pba, bit wide, int addr, logic [63:0] exp);
    h_req = 1; h_we = 0; h_pba = pba; h_wide = wide; h_addr = AW'(addr);
    tick();
    chk(tag, "read strobe", 64'(rvalid), 64'h1);
    chk(tag, "read data", rdata, exp);
  endtask

  task automatic devreq(int v);
    d_req = 1; d_vec = VW'(v);
    tick();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        fails++;
        $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    cur_req = "R1";
    chk("R1", "msg_valid after reset", 64'(mvalid), 64'h0);
    hread("R1", 0, 0, 12, 64'h1);
    hread("R1", 0, 0, 71 * 16 + 12, 64'h1);
    hread("R1", 0, 0, 5 * 16, 64'h0);
    hread("R1", 1, 1, 8, 64'h0);
    cur_req = "R11";
    tick();
    chk("R11", "no strobe when idle", 64'(rvalid), 64'h0);

    cur_req = "R2";
    hwrite(0, 0, 'h30, 64'h1000_0040);
    hwrite(0, 0, 'h34, 64'h0000_00FE);
    hwrite(0, 0, 'h38, 64'h0000_4123);
    hread("R2", 0, 0, 'h30, 64'h1000_0040);
    hread("R2", 0, 0, 'h34, 64'h0000_00FE);
    hread("R2", 0, 0, 'h38, 64'h0000_4123);
    hread("R2", 0, 0, 'h3C, 64'h1);

    cur_req = "R3";
    hwrite(0, 1, 'h90, 64'h1111_2222_3333_4444);
    hread("R3", 0, 0, 'h90, 64'h3333_4444);
    hread("R3", 0, 0, 'h94, 64'h1111_2222);
    hwrite(0, 1, 'h98, 64'h0000_0001_0000_ABCD);
    hread("R3", 0, 1, 'h98, 64'h0000_0001_0000_ABCD);
    hread("R3", 0, 0, 'h9C, 64'h1);
    hread("R3", 0, 1, 'h30, 64'h0000_00FE_1000_0040);

    cur_req = "R4";
    hwrite(0, 1, 'h34, 64'hFFFF_FFFF_FFFF_FFFF);
    hwrite(0, 0, 'h31, 64'hFFFF_FFFF);
    hread("R4", 0, 0, 'h30, 64'h1000_0040);
    hread("R4", 0, 0, 'h34, 64'h0000_00FE);
    hread("R4", 0, 0, 'h32, 64'h0);
    hread("R4", 0, 1, 'h3C, 64'h0);

    cur_req = "R7";
    hwrite(0, 1, 'h38, 64'h0000_0000_0000_4123);
    fen = 1; fmask = 0; rdy = 1;
    devreq(3);
    chk("R7", "direct msg_valid", 64'(mvalid), 64'h1);
    chk("R7", "direct msg_addr", maddr, 64'h0000_00FE_1000_0040);
    chk("R7", "direct msg_data", 64'(mdata), 64'h4123);
    tick();
    chk("R7", "slot drained", 64'(mvalid), 64'h0);
    hread("R7", 1, 0, 0, 64'h0);

    cur_req = "R8";
    devreq(70);
    devreq(40);
    chk("R8", "no msg for masked vector", 64'(mvalid), 64'h0);
    cur_req = "R5";
    hread("R5", 1, 0, 8, 64'h40);
    hread("R5", 1, 0, 4, 64'h100);
    hread("R5", 1, 1, 8, 64'h40);
    hread("R5", 1, 1, 0, 64'h0000_0100_0000_0000);
    hread("R5", 1, 0, 12, 64'h0);

    cur_req = "R6";
    hwrite(1, 1, 0, 64'h0);
    hwrite(1, 0, 8, 64'hFFFF_FFFF);
    hread("R6", 1, 0, 4, 64'h100);
    hread("R6", 1, 0, 8, 64'h40);

    cur_req = "R9";
    rdy = 0;
    hwrite(0, 0, 70 * 16, 64'hA0);
    hwrite(0, 0, 70 * 16 + 8, 64'h77);
    hwrite(0, 0, 70 * 16 + 12, 64'h0);
    tick();
    chk("R9", "release msg_valid", 64'(mvalid), 64'h1);
    chk("R9", "release msg_addr", maddr, 64'hA0);
    chk("R9", "release msg_data", 64'(mdata), 64'h77);
    cur_req = "R10";
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R10", "held msg_valid", 64'(mvalid), 64'h1);
      chk("R10", "held msg_addr", maddr, 64'hA0);
    end
    hread("R9", 1, 0, 8, 64'h40);
    cur_req = "R9";
    rdy = 1;
    tick();
    chk("R9", "accepted", 64'(mvalid), 64'h0);
    hread("R9", 1, 0, 8, 64'h0);

    cur_req = "R8";
    fmask = 1;
    devreq(3);
    chk("R8", "function masked no msg", 64'(mvalid), 64'h0);
    hread("R8", 1, 0, 0, 64'h8);
    cur_req = "R9";
    fmask = 0;
    tick();
    chk("R9", "function unmask release", 64'(mvalid), 64'h1);
    chk("R9", "function unmask addr", maddr, 64'h0000_00FE_1000_0040);
    tick();
    hread("R9", 1, 0, 0, 64'h0);

    cur_req = "R9";
    for (int c = 0; c < 4000; c++) begin
      if (c % 50 == 0) begin
        fen = ($urandom % 10) != 0;
        fmask = ($urandom % 5) == 0;
      end
      rdy = $urandom % 2;
      if ($urandom % 3 == 0) begin
        d_req = 1; d_vec = VW'($urandom % 80);
      end
      if ($urandom % 2 == 0) begin
        h_req = 1; h_we = $urandom % 2; h_pba = ($urandom % 4) == 0;
        h_wide = $urandom % 2;
        h_addr = h_pba ? AW'($urandom % 24) : AW'($urandom % (NV * 16));
        if ($urandom % 3 == 0) h_addr = AW'(int'(h_addr) & ~3);
        h_wdata = {$urandom, $urandom};
        if (h_wide && $urandom % 2 == 0) h_wdata[32] = $urandom % 4 == 0;
        else if (!h_wide) h_wdata[0] = $urandom % 4 == 0;
      end
      tick();
    end
    summary();
  end
endmodule